// File: doc/BRIEF.md
# Clock Output Gating Controller

This block decides, for every differential clock output of a clock generator, whether the output buffer runs, is parked low, or floats. It covers eight SRC pairs, two auxiliary graphics pairs and three CPU pairs. Each output has a master-enable bit from the configuration registers. A subset of the SRC outputs can also be gated by two active-low external request pins, and each of these outputs selects the pins that govern it through its own mapping bits. The CPU outputs can be halted by an active-low stop pin, but only where a per-output stoppable flag is set. An asynchronous power-down input silences everything at once. One global bit chooses whether a disabled pair floats or is driven low.

The request pins and the stop pin come from outside the chip, so they pass through two-flop synchronizers. The resulting enable for each output is then held in a register that only accepts a new value at an edge where that output's clock level input reads low. An output is therefore never cut or started partway through a high phase.

The configuration bits come from a register file outside this block. At reset the mapping bits read "does not control", the master enables read "enabled", and the stoppable flags of CPU1 and CPU2 read "stoppable".

Top module: `clkgate_ctrl`

## Requirements
- R1: Each request pin is active low. When a pin reads 0, the outputs mapped to it are allowed to run; when it reads 1, those outputs are disabled.
- R2: An SRC output is governed by request pin A only when its `src_map_a` bit is 1, and by pin B only when its `src_map_b` bit is 1. An output with both bits 0 ignores both pins.
- R3: Only SRC outputs whose bit is set in `SRC_REQ_CAP` (default 8'b1111_1001, i.e. outputs 0, 3, 4, 5, 6 and 7) can be gated by request pins. Mapping bits for outputs 1 and 2 have no effect. Graphics and CPU outputs are never gated by request pins.
- R4: A master-enable bit of 0 disables its output, whatever the request and stop pins read.
- R5: When `cpu_stop_n` reads 0, every CPU output whose `cpu_stop_en` bit is 1 is disabled. CPU outputs whose bit is 0 keep running.
- R6: A disabled output asserts its `*_hiz` bit when `dis_hiz` is 1, and leaves it 0 (driven low) when `dis_hiz` is 0. An enabled output never asserts `*_hiz`. The mode bit acts in the same cycle.
- R7: While `pwr_down` is 1, all enables are 0, immediately and without waiting for a clock edge. Releasing it restores the held enables at once.
- R8: If an SRC output is mapped to both request pins, either pin reading 1 disables it.
- R9: The request and stop pins are synchronized by two flops. A pin change becomes visible at the outputs after the third rising clock edge, and not after the second. A change of a configuration bit becomes visible after the first edge.
- R10: The held enable of an output changes only at an edge where that output's clock level input (`src_lvl`, `gfx_lvl`, `cpu_lvl`, 1 = high) reads 0. While the level reads 1, the enable keeps its old value.
- R11: During reset all enables are 0, the synchronized pins read 1 (deasserted), and each `*_hiz` equals `dis_hiz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Asynchronous active-high power-down |
| req_a_n | input | 1 | Request pin A, active low |
| req_b_n | input | 1 | Request pin B, active low |
| cpu_stop_n | input | 1 | CPU stop pin, active low |
| dis_hiz | input | 1 | 1: disabled pairs float; 0: driven low |
| src_master | input | NUM_SRC | SRC master enables |
| src_map_a | input | NUM_SRC | SRC output governed by pin A |
| src_map_b | input | NUM_SRC | SRC output governed by pin B |
| gfx_master | input | NUM_GFX | Graphics master enables |
| cpu_master | input | NUM_CPU | CPU master enables |
| cpu_stop_en | input | NUM_CPU | CPU output is stoppable |
| src_lvl | input | NUM_SRC | Current level of each SRC clock |
| gfx_lvl | input | NUM_GFX | Current level of each graphics clock |
| cpu_lvl | input | NUM_CPU | Current level of each CPU clock |
| src_en | output | NUM_SRC | SRC output enables |
| src_hiz | output | NUM_SRC | SRC high-impedance controls |
| gfx_en | output | NUM_GFX | Graphics output enables |
| gfx_hiz | output | NUM_GFX | Graphics high-impedance controls |
| cpu_en | output | NUM_CPU | CPU output enables |
| cpu_hiz | output | NUM_CPU | CPU high-impedance controls |

## Verification
The results come due at three different latencies. Power-down and the disabled-state mode act in the same cycle as the stimulus. Configuration bits take effect one rising edge later. Pin changes take effect three rising edges later. The driver changes inputs at a falling edge and queues each expected result together with the cycle number at which it is due. The monitor compares a queued item only once that cycle has been reached, sampling just after the falling edge. For the pins, the bench also queues a check one edge early, confirming that the old value still holds after the second edge. Cases where the clock level is high are checked both while the enable is held and after the level falls.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
    // external pins after synchronization, 1 = deasserted for all three
    typedef struct packed {
        logic req_a;
        logic req_b;
        logic stop;
    } pin_vec_t;

    typedef struct packed {
        pin_vec_t s1;
        pin_vec_t s2;
    } sync_st_t;
endpackage

// File: rtl/clkgate_sync.sv
`timescale 1ns/1ps
module clkgate_sync
    import clkgate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pins_in,
    output pin_vec_t pins_out
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pins_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign pins_out = st_q.s2;
endmodule

// File: rtl/clkgate_hold.sv
`timescale 1ns/1ps
module clkgate_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] want,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] en
);
    logic [W-1:0] en_d, en_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb en_d[i] = lvl[i] ? en_q[i] : want[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    // R10
    hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((en_q ^ $past(en_q)) & $past(lvl)) == '0));

    // R10
    hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((en_q ^ $past(want)) & ~$past(lvl)) == '0));
endmodule

// File: rtl/clkgate_ctrl.sv
`timescale 1ns/1ps
module clkgate_ctrl
    import clkgate_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_GFX = 2,
    parameter int NUM_CPU = 3,
    parameter logic [NUM_SRC-1:0] SRC_REQ_CAP = 8'b1111_1001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_down,
    input  logic               req_a_n,
    input  logic               req_b_n,
    input  logic               cpu_stop_n,
    input  logic               dis_hiz,
    input  logic [NUM_SRC-1:0] src_master,
    input  logic [NUM_SRC-1:0] src_map_a,
    input  logic [NUM_SRC-1:0] src_map_b,
    input  logic [NUM_GFX-1:0] gfx_master,
    input  logic [NUM_CPU-1:0] cpu_master,
    input  logic [NUM_CPU-1:0] cpu_stop_en,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_GFX-1:0] gfx_lvl,
    input  logic [NUM_CPU-1:0] cpu_lvl,
    output logic [NUM_SRC-1:0] src_en,
    output logic [NUM_SRC-1:0] src_hiz,
    output logic [NUM_GFX-1:0] gfx_en,
    output logic [NUM_GFX-1:0] gfx_hiz,
    output logic [NUM_CPU-1:0] cpu_en,
    output logic [NUM_CPU-1:0] cpu_hiz
);
    pin_vec_t pins_raw, pins_s;
    logic [NUM_SRC-1:0] src_want, src_held;
    logic [NUM_CPU-1:0] cpu_want, cpu_held;
    logic [NUM_GFX-1:0] gfx_held;

    assign pins_raw = '{req_a: req_a_n, req_b: req_b_n, stop: cpu_stop_n};

    clkgate_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (pins_raw),
        .pins_out (pins_s)
    );

    // request gating only exists on capable SRC positions
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (SRC_REQ_CAP[i]) begin : g_cap
            always_comb src_want[i] = src_master[i]
                                    & ~(src_map_a[i] & pins_s.req_a)
                                    & ~(src_map_b[i] & pins_s.req_b);
        end else begin : g_fixed
            always_comb src_want[i] = src_master[i];
        end
    end

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        always_comb cpu_want[i] = cpu_master[i] & ~(cpu_stop_en[i] & ~pins_s.stop);
    end

    clkgate_hold #(.W(NUM_SRC)) u_src_hold (
        .clk(clk), .rst_n(rst_n), .want(src_want), .lvl(src_lvl), .en(src_held));
    clkgate_hold #(.W(NUM_GFX)) u_gfx_hold (
        .clk(clk), .rst_n(rst_n), .want(gfx_master), .lvl(gfx_lvl), .en(gfx_held));
    clkgate_hold #(.W(NUM_CPU)) u_cpu_hold (
        .clk(clk), .rst_n(rst_n), .want(cpu_want), .lvl(cpu_lvl), .en(cpu_held));

    // power-down overrides asynchronously
    always_comb begin
        src_en  = pwr_down ? '0 : src_held;
        gfx_en  = pwr_down ? '0 : gfx_held;
        cpu_en  = pwr_down ? '0 : cpu_held;
        src_hiz = ~src_en & {NUM_SRC{dis_hiz}};
        gfx_hiz = ~gfx_en & {NUM_GFX{dis_hiz}};
        cpu_hiz = ~cpu_en & {NUM_CPU{dis_hiz}};
    end

    // R7
    pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (src_en == '0 && gfx_en == '0 && cpu_en == '0));

    // R6
    hiz_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_hiz & src_en) == '0) && ((gfx_hiz & gfx_en) == '0) && ((cpu_hiz & cpu_en) == '0));
endmodule

// File: tb/clkgate_ctrl_test.sv
`timescale 1ns/1ps
module clkgate_ctrl_test;
    localparam int NS = 8, NG = 2, NC = 3;
    localparam logic [NS-1:0] CAP = 8'b1111_1001;

    logic clk = 0, rst_n = 0, pwr_down = 0;
    logic req_a_n = 1, req_b_n = 1, cpu_stop_n = 1, dis_hiz = 0;
    logic [NS-1:0] src_master = '1, src_map_a = '0, src_map_b = '0, src_lvl = '0;
    logic [NG-1:0] gfx_master = '1, gfx_lvl = '0;
    logic [NC-1:0] cpu_master = '1, cpu_stop_en = 3'b110, cpu_lvl = '0;
    logic [NS-1:0] src_en, src_hiz;
    logic [NG-1:0] gfx_en, gfx_hiz;
    logic [NC-1:0] cpu_en, cpu_hiz;

    clkgate_ctrl uut (.*);

    always #2.5 clk = ~clk;

    int cyc = 0;
    int checks = 0, errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [NS-1:0] s_en, s_hz;
        logic [NG-1:0] g_en, g_hz;
        logic [NC-1:0] c_en, c_hz;
        int due;
        string tag;
    } item_t;

    item_t sb[$];

    // steady-state expectation from the requirements
    function automatic item_t model();
        item_t it;
        for (int i = 0; i < NS; i++) begin
            logic w;
            w = src_master[i];                                  // R4
            if (CAP[i] && src_map_a[i] && req_a_n) w = 0;       // R1 R2 R3
            if (CAP[i] && src_map_b[i] && req_b_n) w = 0;       // R8
            it.s_en[i] = w && !pwr_down;                        // R7
        end
        for (int i = 0; i < NG; i++) it.g_en[i] = gfx_master[i] && !pwr_down;
        for (int i = 0; i < NC; i++)
            it.c_en[i] = cpu_master[i] && !(cpu_stop_en[i] && !cpu_stop_n) && !pwr_down; // R5
        it.s_hz = ~it.s_en & {NS{dis_hiz}};                     // R6
        it.g_hz = ~it.g_en & {NG{dis_hiz}};
        it.c_hz = ~it.c_en & {NC{dis_hiz}};
        return it;
    endfunction

    task automatic push(input item_t it, input int n, input string tag);
        it.due = cyc + n;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic expect_model(input int n, input string tag);
        push(model(), n, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    initial forever begin
        @(negedge clk);
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (src_en !== it.s_en || src_hiz !== it.s_hz || gfx_en !== it.g_en ||
                gfx_hiz !== it.g_hz || cpu_en !== it.c_en || cpu_hiz !== it.c_hz) begin
                errors++;
                $display("FAIL %s: en src=%b gfx=%b cpu=%b hiz src=%b gfx=%b cpu=%b expected en src=%b gfx=%b cpu=%b hiz src=%b gfx=%b cpu=%b",
                         it.tag, src_en, gfx_en, cpu_en, src_hiz, gfx_hiz, cpu_hiz,
                         it.s_en, it.g_en, it.c_en, it.s_hz, it.g_hz, it.c_hz);
            end
        end
    end

    task automatic run_tests();
        item_t it;
        @(negedge clk);
        // R11 reset state
        it = '{s_en:'0, s_hz:'0, g_en:'0, g_hz:'0, c_en:'0, c_hz:'0, due:0, tag:""};
        push(it, 0, "R11 reset enables off");
        idle(1);
        dis_hiz = 1;
        it.s_hz = '1; it.g_hz = '1; it.c_hz = '1;
        push(it, 0, "R11 R6 reset hiz follows mode");
        idle(1);
        dis_hiz = 0;
        rst_n = 1;
        expect_model(1, "R11 after release enables follow masters");
        idle(2);

        // R4 master enables
        src_master[5] = 0; cpu_master[0] = 0; gfx_master[1] = 0;
        expect_model(1, "R4 master disable");
        idle(2);
        dis_hiz = 1;
        expect_model(0, "R6 disabled pairs float");
        idle(1);
        dis_hiz = 0;
        expect_model(0, "R6 disabled pairs driven low");
        idle(1);
        src_master = '1; cpu_master = '1; gfx_master = '1;
        expect_model(1, "R4 master restore");
        idle(2);

        // R2 R1 mapping to pin A
        src_map_a = 8'b0000_1001;
        expect_model(1, "R2 R1 mapped outputs off with pin A high");
        idle(2);
        src_master[3] = 0;
        src_master[3] = 1;
        req_a_n = 0;
        it = model();
        it.s_en[0] = 0; it.s_en[3] = 0; it.s_hz = '0;
        push(it, 2, "R9 pin A not yet visible after two edges");
        expect_model(3, "R1 R9 pin A low enables after three edges");
        idle(4);

        // R3 non-capable outputs ignore mapping
        src_map_a = 8'b0000_1111;
        req_a_n = 1;
        expect_model(3, "R3 outputs 1 2 ignore pin A");
        idle(4);
        req_a_n = 0;
        src_map_a = 8'b0001_0000;
        src_map_b = 8'b0001_0000;
        req_b_n = 0;
        expect_model(3, "R8 both pins low output 4 runs");
        idle(4);
        req_b_n = 1;
        expect_model(3, "R8 pin B high disables dual-mapped output");
        idle(4);
        req_b_n = 0; req_a_n = 1;
        expect_model(3, "R8 pin A high disables dual-mapped output");
        idle(4);
        req_a_n = 0;
        src_map_a = '0; src_map_b = '0;
        expect_model(3, "R2 unmapped outputs run");
        idle(4);

        // R5 cpu stop
        cpu_stop_n = 0;
        it = model();
        it.c_en = 3'b111; it.c_hz = '0;
        push(it, 2, "R9 stop not yet visible after two edges");
        expect_model(3, "R5 stoppable cpu outputs halt, cpu0 free-runs");
        idle(4);
        cpu_stop_en = 3'b001;
        expect_model(1, "R5 stop flags swapped");
        idle(2);
        cpu_stop_n = 1; cpu_stop_en = 3'b110;
        expect_model(3, "R5 stop released");
        idle(4);

        // R10 level-gated update
        src_lvl[6] = 1; cpu_lvl[1] = 1;
        src_master[6] = 0; cpu_master[1] = 0;
        it = model();
        it.s_en[6] = 1; it.c_en[1] = 1;
        push(it, 1, "R10 enable held while clock high");
        idle(3);
        it = model();
        it.s_en[6] = 1; it.c_en[1] = 1;
        push(it, 0, "R10 still held");
        idle(1);
        src_lvl[6] = 0; cpu_lvl[1] = 0;
        expect_model(1, "R10 update once clock low");
        idle(2);

        // R7 power-down
        src_master = '1; cpu_master = '1;
        idle(2);
        dis_hiz = 1;
        pwr_down = 1;
        expect_model(0, "R7 power-down same cycle");
        idle(2);
        pwr_down = 0;
        expect_model(0, "R7 power-down release restores");
        idle(2);
        dis_hiz = 0;
        idle(1);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #(100000 * 5);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard left %0d items, expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule